// File: doc/BRIEF.md
# Port-Bound Reservation Station Selector

This block is a unified scheduling window of twenty micro-op slots that feeds five execution ports. Each micro-op is tied to exactly one port at the moment it is written into the window. Integer ALU ops could run on either of two ports, but they are spread across the two by alternation and then stay on the port they were given. Multiply, divide and FP-multiply ops always go to port 0. Jump and FP-add ops always go to port 1. Ports 2, 3 and 4 take load-address, store-address and store-data ops.

Because each op is tied to one port, every port only has to pick one op from the slots bound to it, with no global matching across ports. The pick is oldest-first, using an age matrix updated on every allocation. An op whose port is busy keeps waiting, even when the sibling ALU port has nothing to do.

Each slot is a small state machine with three states. `E_FREE` means the slot is empty. `E_WAIT` means it holds an op that still waits for an operand. `E_READY` means both operands are available. The transitions are:
- alloc-ready: `E_FREE` to `E_READY`
- alloc-pending: `E_FREE` to `E_WAIT`
- wakeup-complete: `E_WAIT` to `E_READY`
- dispatch: `E_READY` to `E_FREE`

Operand readiness comes from tag broadcasts on the wakeup bus.

Top module: `rs_port_select`

## Requirements
- R1: After reset every slot is free, `disp_valid` is all zero and `alloc_stall` is low.
- R2: Op class codes bind as follows:
  - 1 (multiply), 2 (divide) and 3 (FP multiply) go to port 0.
  - 4 (jump) and 5 (FP add) go to port 1.
  - 6 (load address) goes to port 2, 7 (store address) to port 3 and 8 (store data) to port 4.
  - Codes 9 to 15 go to port 0.
  - `disp_id` slice p (bits p*8 upward) carries the `alloc_id` of the op dispatched on port p.
- R3: Class 0 (integer ALU) ops are bound alternately to port 0 and port 1, starting with port 0 after reset. The alternation advances only on an accepted ALU allocation.
- R4: While `port_busy[p]` is high, port p dispatches nothing. Ops bound to it keep waiting, even if the other ALU port is idle.
- R5: When several ready ops are bound to one port, the port dispatches them in allocation order, one per cycle.
- R6: Each port dispatches at most one op per cycle, and no slot is dispatched on two ports. Ops on all five ports can dispatch in the same cycle.
- R7: `alloc_stall` is high exactly when all twenty slots are occupied. An allocation presented while it is high is dropped and never dispatches.
- R8: An operand becomes ready when a valid wakeup tag equals its tag. An op is not dispatched until both operands are ready. An allocation also matches wakeup tags broadcast in its own cycle.
- R9: An op that is allocated with both operands ready is visible on `disp_valid` in the cycle after its allocation edge. Its slot is freed at the edge that ends the dispatch cycle, so it is never dispatched twice.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| alloc_valid | input | 1 | Allocation request |
| alloc_class | input | 4 | Op class code |
| alloc_id | input | ID_W (8) | Op identifier returned on dispatch |
| alloc_tag_a | input | TAG_W (6) | Tag of first source operand |
| alloc_rdy_a | input | 1 | First source already available |
| alloc_tag_b | input | TAG_W (6) | Tag of second source operand |
| alloc_rdy_b | input | 1 | Second source already available |
| alloc_stall | output | 1 | All slots occupied; allocation refused |
| wake_valid | input | N_WAKE (2) | Wakeup broadcast valid, one per lane |
| wake_tag | input | N_WAKE*TAG_W (12) | Wakeup tags, lane w at bits w*TAG_W upward |
| port_busy | input | N_PORTS (5) | Per-port busy; blocks dispatch on that port |
| disp_valid | output | N_PORTS (5) | Per-port dispatch valid |
| disp_id | output | N_PORTS*ID_W (40) | Per-port dispatched op identifier |

## Verification
The mapping is tried with one ready op at a time over every class, including three ALU ops. This tells the fixed binding apart from the alternation, and shows whether the alternation counts only ALU allocations. Several ALU ops are queued behind a busy port 0 while port 1 stays idle. This separates a port-bound picker from one that would steal the idle sibling, and the drain order after release exposes any age-ordering error. Further patterns cover the following:
- a full station with an extra allocation attempt, which tells a dropped request from an overwrite;
- a mixed group of one op per port released together, which shows independent per-port selection;
- a pending operand woken by a matching, a non-matching and a same-cycle tag.

// File: rtl/rs_pkg.sv
package rs_pkg;

    typedef enum logic [3:0] {
        OP_ALU  = 4'd0,
        OP_IMUL = 4'd1,
        OP_IDIV = 4'd2,
        OP_FMUL = 4'd3,
        OP_JUMP = 4'd4,
        OP_FADD = 4'd5,
        OP_LOAD = 4'd6,
        OP_STA  = 4'd7,
        OP_STD  = 4'd8
    } op_class_e;

    typedef enum logic [1:0] {
        E_FREE  = 2'd0,
        E_WAIT  = 2'd1,
        E_READY = 2'd2
    } ent_state_e;

endpackage

// File: rtl/rs_port_map.sv
module rs_port_map
    import rs_pkg::*;
#(
    parameter int PORT_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [3:0]        op_class,
    input  logic              accept,
    output logic [PORT_W-1:0] port
);

    // Selects the integer port for the next ALU op: 0 -> port 0, 1 -> port 1
    logic alu_side_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            alu_side_q <= 1'b0;
        end else if (accept && op_class == OP_ALU) begin
            alu_side_q <= ~alu_side_q;
        end
    end

    always_comb begin
        case (op_class)
            OP_ALU:                   port = alu_side_q ? PORT_W'(1) : PORT_W'(0);
            OP_IMUL, OP_IDIV, OP_FMUL: port = PORT_W'(0);
            OP_JUMP, OP_FADD:          port = PORT_W'(1);
            OP_LOAD:                   port = PORT_W'(2);
            OP_STA:                    port = PORT_W'(3);
            OP_STD:                    port = PORT_W'(4);
            default:                   port = PORT_W'(0);
        endcase
    end

endmodule

// File: rtl/rs_entry.sv
module rs_entry
    import rs_pkg::*;
#(
    parameter int TAG_W  = 6,
    parameter int ID_W   = 8,
    parameter int PORT_W = 3,
    parameter int N_WAKE = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    alloc_we,
    input  logic [PORT_W-1:0]       alloc_port,
    input  logic [ID_W-1:0]         alloc_id,
    input  logic [TAG_W-1:0]        alloc_tag_a,
    input  logic                    alloc_rdy_a,
    input  logic [TAG_W-1:0]        alloc_tag_b,
    input  logic                    alloc_rdy_b,
    input  logic [N_WAKE-1:0]       wake_valid,
    input  logic [N_WAKE*TAG_W-1:0] wake_tag,
    input  logic                    grant,
    output logic                    busy,
    output logic                    ready,
    output logic [PORT_W-1:0]       port,
    output logic [ID_W-1:0]         id
);

    ent_state_e        state_q, state_d;
    logic [TAG_W-1:0]  tag_a_q, tag_b_q;
    logic              rdy_a_q, rdy_b_q;
    logic [PORT_W-1:0] port_q;
    logic [ID_W-1:0]   id_q;

    logic hit_new_a, hit_new_b, hit_old_a, hit_old_b;
    logic rdy_new_a, rdy_new_b, rdy_now_a, rdy_now_b;

    // Tag compare against every wakeup lane, for the incoming op and the held op
    always_comb begin
        hit_new_a = 1'b0;
        hit_new_b = 1'b0;
        hit_old_a = 1'b0;
        hit_old_b = 1'b0;
        for (int w = 0; w < N_WAKE; w++) begin
            if (wake_valid[w]) begin
                if (wake_tag[w*TAG_W +: TAG_W] == alloc_tag_a) hit_new_a = 1'b1;
                if (wake_tag[w*TAG_W +: TAG_W] == alloc_tag_b) hit_new_b = 1'b1;
                if (wake_tag[w*TAG_W +: TAG_W] == tag_a_q)     hit_old_a = 1'b1;
                if (wake_tag[w*TAG_W +: TAG_W] == tag_b_q)     hit_old_b = 1'b1;
            end
        end
        rdy_new_a = alloc_rdy_a | hit_new_a;
        rdy_new_b = alloc_rdy_b | hit_new_b;
        rdy_now_a = rdy_a_q | hit_old_a;
        rdy_now_b = rdy_b_q | hit_old_b;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            E_FREE:  if (alloc_we) state_d = (rdy_new_a && rdy_new_b) ? E_READY : E_WAIT;
            E_WAIT:  if (rdy_now_a && rdy_now_b) state_d = E_READY;
            E_READY: if (grant) state_d = E_FREE;
            default: state_d = E_FREE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= E_FREE;
        end else begin
            state_q <= state_d;
        end
    end

    // Payload and operand-ready bits
    always_ff @(posedge clk) begin
        if (rst) begin
            rdy_a_q <= 1'b0;
            rdy_b_q <= 1'b0;
            tag_a_q <= '0;
            tag_b_q <= '0;
            port_q  <= '0;
            id_q    <= '0;
        end else if (alloc_we && state_q == E_FREE) begin
            rdy_a_q <= rdy_new_a;
            rdy_b_q <= rdy_new_b;
            tag_a_q <= alloc_tag_a;
            tag_b_q <= alloc_tag_b;
            port_q  <= alloc_port;
            id_q    <= alloc_id;
        end else if (state_q == E_WAIT) begin
            rdy_a_q <= rdy_now_a;
            rdy_b_q <= rdy_now_b;
        end
    end

    // Outputs
    always_comb begin
        busy  = (state_q != E_FREE);
        ready = (state_q == E_READY);
        port  = port_q;
        id    = id_q;
    end

endmodule

// File: rtl/rs_pick.sv
module rs_pick #(
    parameter int N = 20
) (
    input  logic [N-1:0] req,
    input  logic [N-1:0] older [N],
    output logic [N-1:0] gnt
);

    // older[i][j] set means slot j was allocated before slot i
    always_comb begin
        for (int i = 0; i < N; i++) begin
            gnt[i] = req[i] && ((req & older[i]) == '0);
        end
    end

endmodule

// File: rtl/rs_port_select.sv
module rs_port_select
    import rs_pkg::*;
#(
    parameter int N_ENTRIES = 20,
    parameter int N_PORTS   = 5,
    parameter int TAG_W     = 6,
    parameter int ID_W      = 8,
    parameter int N_WAKE    = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      alloc_valid,
    input  logic [3:0]                alloc_class,
    input  logic [ID_W-1:0]           alloc_id,
    input  logic [TAG_W-1:0]          alloc_tag_a,
    input  logic                      alloc_rdy_a,
    input  logic [TAG_W-1:0]          alloc_tag_b,
    input  logic                      alloc_rdy_b,
    output logic                      alloc_stall,
    input  logic [N_WAKE-1:0]         wake_valid,
    input  logic [N_WAKE*TAG_W-1:0]   wake_tag,
    input  logic [N_PORTS-1:0]        port_busy,
    output logic [N_PORTS-1:0]        disp_valid,
    output logic [N_PORTS*ID_W-1:0]   disp_id
);

    localparam int PORT_W = (N_PORTS > 1) ? $clog2(N_PORTS) : 1;

    logic [N_ENTRIES-1:0]         ent_busy;
    logic [N_ENTRIES-1:0]         ent_ready;
    logic [PORT_W-1:0]            ent_port [N_ENTRIES];
    logic [ID_W-1:0]              ent_id   [N_ENTRIES];
    logic [N_ENTRIES-1:0]         alloc_oh;
    logic                         alloc_accept;
    logic [PORT_W-1:0]            alloc_port;
    logic [N_ENTRIES-1:0]         older_q  [N_ENTRIES];
    logic [N_ENTRIES-1:0]         req_p    [N_PORTS];
    logic [N_ENTRIES-1:0]         gnt_p    [N_PORTS];
    logic [N_ENTRIES-1:0]         grant_any;
    logic [N_PORTS*N_ENTRIES-1:0] gnt_flat;

    // Lowest free slot receives the allocation
    always_comb begin
        logic found;
        found    = 1'b0;
        alloc_oh = '0;
        for (int i = 0; i < N_ENTRIES; i++) begin
            if (!ent_busy[i] && !found) begin
                alloc_oh[i] = 1'b1;
                found       = 1'b1;
            end
        end
        alloc_stall  = !found;
        alloc_accept = alloc_valid && found;
    end

    rs_port_map #(.PORT_W(PORT_W)) u_map (
        .clk      (clk),
        .rst      (rst),
        .op_class (alloc_class),
        .accept   (alloc_accept),
        .port     (alloc_port)
    );

    // Age matrix: a new slot is younger than every slot occupied at allocation
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N_ENTRIES; i++) older_q[i] <= '0;
        end else if (alloc_accept) begin
            for (int i = 0; i < N_ENTRIES; i++) begin
                if (alloc_oh[i]) older_q[i] <= ent_busy;
                else             older_q[i] <= older_q[i] & ~alloc_oh;
            end
        end
    end

    for (genvar e = 0; e < N_ENTRIES; e++) begin : g_ent
        rs_entry #(
            .TAG_W(TAG_W), .ID_W(ID_W), .PORT_W(PORT_W), .N_WAKE(N_WAKE)
        ) u_ent (
            .clk         (clk),
            .rst         (rst),
            .alloc_we    (alloc_accept && alloc_oh[e]),
            .alloc_port  (alloc_port),
            .alloc_id    (alloc_id),
            .alloc_tag_a (alloc_tag_a),
            .alloc_rdy_a (alloc_rdy_a),
            .alloc_tag_b (alloc_tag_b),
            .alloc_rdy_b (alloc_rdy_b),
            .wake_valid  (wake_valid),
            .wake_tag    (wake_tag),
            .grant       (grant_any[e]),
            .busy        (ent_busy[e]),
            .ready       (ent_ready[e]),
            .port        (ent_port[e]),
            .id          (ent_id[e])
        );
    end

    // Per-port request vectors
    always_comb begin
        for (int p = 0; p < N_PORTS; p++) begin
            for (int i = 0; i < N_ENTRIES; i++) begin
                req_p[p][i] = ent_ready[i] && (ent_port[i] == PORT_W'(p)) && !port_busy[p];
            end
        end
    end

    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        rs_pick #(.N(N_ENTRIES)) u_pick (
            .req   (req_p[p]),
            .older (older_q),
            .gnt   (gnt_p[p])
        );
        assign gnt_flat[p*N_ENTRIES +: N_ENTRIES] = gnt_p[p];
    end

    // Dispatch outputs
    always_comb begin
        grant_any = '0;
        disp_id   = '0;
        for (int p = 0; p < N_PORTS; p++) begin
            disp_valid[p] = |gnt_p[p];
            grant_any     = grant_any | gnt_p[p];
            for (int i = 0; i < N_ENTRIES; i++) begin
                if (gnt_p[p][i]) disp_id[p*ID_W +: ID_W] = disp_id[p*ID_W +: ID_W] | ent_id[i];
            end
        end
    end

endmodule

// File: rtl/rs_port_select_chk.sv
module rs_port_select_chk #(
    parameter int N_ENTRIES = 20,
    parameter int N_PORTS   = 5
) (
    input logic                         clk,
    input logic                         rst,
    input logic [N_PORTS-1:0]           port_busy,
    input logic [N_PORTS-1:0]           disp_valid,
    input logic                         alloc_stall,
    input logic [N_ENTRIES-1:0]         ent_busy,
    input logic [N_PORTS*N_ENTRIES-1:0] gnt_flat
);

    logic [N_ENTRIES-1:0] granted;

    always_comb begin
        granted = '0;
        for (int p = 0; p < N_PORTS; p++) granted = granted | gnt_flat[p*N_ENTRIES +: N_ENTRIES];
    end

    // R1: quiet outputs on the first cycle out of reset
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (disp_valid == '0 && !alloc_stall));

    // R7: stalled with no dispatch keeps the station full and stalled
    a_r7_full_holds: assert property (@(posedge clk) disable iff (rst)
        (alloc_stall && granted == '0) |=> (&ent_busy && alloc_stall));

    for (genvar p = 0; p < N_PORTS; p++) begin : g_p
        // R4: a busy port dispatches nothing
        a_r4_busy_blocks: assert property (@(posedge clk) disable iff (rst)
            port_busy[p] |-> !disp_valid[p]);
        // R6: at most one slot per port
        a_r6_one_per_port: assert property (@(posedge clk) disable iff (rst)
            $onehot0(gnt_flat[p*N_ENTRIES +: N_ENTRIES]));
    end

    for (genvar i = 0; i < N_ENTRIES; i++) begin : g_e
        // R9: a dispatched slot is free in the next cycle
        a_r9_free_after_issue: assert property (@(posedge clk) disable iff (rst)
            granted[i] |=> !ent_busy[i]);
    end

endmodule

bind rs_port_select rs_port_select_chk #(
    .N_ENTRIES (N_ENTRIES),
    .N_PORTS   (N_PORTS)
) chk_i (
    .clk         (clk),
    .rst         (rst),
    .port_busy   (port_busy),
    .disp_valid  (disp_valid),
    .alloc_stall (alloc_stall),
    .ent_busy    (ent_busy),
    .gnt_flat    (gnt_flat)
);

// File: tb/rs_port_select_tb.sv
`timescale 1ns/1ps
module rs_port_select_tb_top;

    localparam int NP = 5;
    localparam int IW = 8;
    localparam int TW = 6;
    localparam int NV = 11;
    // {class[7:4], expected port[3:0]}
    localparam logic [7:0] VEC [NV] = '{
        8'h00, 8'h10, 8'h41, 8'h01, 8'h62, 8'h73,
        8'h84, 8'h51, 8'h20, 8'h30, 8'h00
    };

    logic            clk = 1'b0;
    logic            rst;
    logic            alloc_valid;
    logic [3:0]      alloc_class;
    logic [IW-1:0]   alloc_id;
    logic [TW-1:0]   alloc_tag_a, alloc_tag_b;
    logic            alloc_rdy_a, alloc_rdy_b;
    logic            alloc_stall;
    logic [1:0]      wake_valid;
    logic [2*TW-1:0] wake_tag;
    logic [NP-1:0]   port_busy;
    logic [NP-1:0]   disp_valid;
    logic [NP*IW-1:0] disp_id;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    rs_port_select dut_i (
        .clk(clk), .rst(rst), .alloc_valid(alloc_valid), .alloc_class(alloc_class),
        .alloc_id(alloc_id), .alloc_tag_a(alloc_tag_a), .alloc_rdy_a(alloc_rdy_a),
        .alloc_tag_b(alloc_tag_b), .alloc_rdy_b(alloc_rdy_b), .alloc_stall(alloc_stall),
        .wake_valid(wake_valid), .wake_tag(wake_tag), .port_busy(port_busy),
        .disp_valid(disp_valid), .disp_id(disp_id)
    );

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int pid(int p);
        return int'(disp_id[p*IW +: IW]);
    endfunction

    task automatic step();
        @(negedge clk);
        alloc_valid = 1'b0;
        wake_valid  = '0;
    endtask

    task automatic alloc(logic [3:0] cls, logic [IW-1:0] id, logic ra, logic [TW-1:0] ta,
                         logic rb, logic [TW-1:0] tb);
        alloc_valid = 1'b1;
        alloc_class = cls;
        alloc_id    = id;
        alloc_rdy_a = ra;
        alloc_tag_a = ta;
        alloc_rdy_b = rb;
        alloc_tag_b = tb;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        alloc_valid = 1'b0;
        wake_valid  = '0;
        port_busy   = '0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1 disp_valid", int'(disp_valid), 0);
        chk("R1 stall", int'(alloc_stall), 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        alloc_valid = 1'b0; alloc_class = '0; alloc_id = '0;
        alloc_tag_a = '0; alloc_tag_b = '0; alloc_rdy_a = 1'b0; alloc_rdy_b = 1'b0;
        wake_valid = '0; wake_tag = '0; port_busy = '0;
        do_reset();

        // Table walk: R2 class binding, R3 ALU alternation, R9 next-cycle dispatch
        for (int k = 0; k < NV; k++) begin
            step();
            alloc(VEC[k][7:4], IW'(20 + k), 1'b1, '0, 1'b1, '0);
            #1;
            step();
            #1;
            chk(VEC[k][7:4] == 4'd0 ? "R3 port" : "R2 port", int'(disp_valid),
                1 << VEC[k][3:0]);
            chk("R2 id", pid(int'(VEC[k][3:0])), 20 + k);
        end
        step(); #1;
        chk("R9 freed after dispatch", int'(disp_valid), 0);

        // R4 / R5: port 0 busy, port 1 free
        do_reset();
        step(); port_busy = 5'b00001; alloc(4'd0, 8'd60, 1, 0, 1, 0); #1;
        step(); alloc(4'd0, 8'd61, 1, 0, 1, 0); #1;
        chk("R4 busy port0 holds op", int'(disp_valid), 0);
        step(); alloc(4'd0, 8'd62, 1, 0, 1, 0); #1;
        chk("R3 second ALU on port1", int'(disp_valid), 5'b00010);
        chk("R3 id", pid(1), 61);
        step(); #1;
        chk("R4 waits while sibling idle", int'(disp_valid), 0);
        step(); port_busy = '0; #1;
        chk("R5 oldest first valid", int'(disp_valid), 5'b00001);
        chk("R5 oldest first id", pid(0), 60);
        step(); #1;
        chk("R5 next oldest valid", int'(disp_valid), 5'b00001);
        chk("R5 next oldest id", pid(0), 62);
        step(); #1;
        chk("R9 drained", int'(disp_valid), 0);

        // R8: wakeup
        step(); alloc(4'd6, 8'd40, 1'b0, 6'd5, 1'b1, 6'd0); #1;
        step(); wake_valid = 2'b01; wake_tag = {6'd0, 6'd6}; #1;
        chk("R8 pending op held", int'(disp_valid), 0);
        step(); wake_valid = 2'b10; wake_tag = {6'd5, 6'd0}; #1;
        chk("R8 wrong tag no wake", int'(disp_valid), 0);
        step(); #1;
        chk("R8 woken valid", int'(disp_valid), 5'b00100);
        chk("R8 woken id", pid(2), 40);
        step(); alloc(4'd7, 8'd41, 1'b0, 6'd9, 1'b1, 6'd0);
        wake_valid = 2'b01; wake_tag = {6'd0, 6'd9}; #1;
        step(); #1;
        chk("R8 same-cycle snoop valid", int'(disp_valid), 5'b01000);
        chk("R8 same-cycle snoop id", pid(3), 41);

        // R6: one op per port, released together
        step(); port_busy = 5'b11111; alloc(4'd1, 8'd50, 1, 0, 1, 0); #1;
        step(); alloc(4'd4, 8'd51, 1, 0, 1, 0); #1;
        step(); alloc(4'd6, 8'd52, 1, 0, 1, 0); #1;
        step(); alloc(4'd7, 8'd53, 1, 0, 1, 0); #1;
        step(); alloc(4'd8, 8'd54, 1, 0, 1, 0); #1;
        step(); port_busy = '0; #1;
        chk("R6 five ports at once", int'(disp_valid), 5'b11111);
        for (int p = 0; p < NP; p++) chk("R6 per-port id", pid(p), 50 + p);
        step(); #1;
        chk("R6 drained", int'(disp_valid), 0);

        // R7: full station
        for (int k = 0; k < 20; k++) begin
            step(); port_busy = 5'b11111; alloc(4'd8, IW'(k), 1, 0, 1, 0); #1;
            if (k == 19) chk("R7 not stalled at 19", int'(alloc_stall), 0);
        end
        step(); alloc(4'd8, 8'd99, 1, 0, 1, 0); #1;
        chk("R7 stall when full", int'(alloc_stall), 1);
        step(); port_busy = 5'b01111; #1;
        chk("R7 drain valid", int'(disp_valid), 5'b10000);
        chk("R7 drain id", pid(4), 0);
        chk("R7 stall held in dispatch cycle", int'(alloc_stall), 1);
        for (int k = 1; k < 20; k++) begin
            step(); #1;
            if (k == 1) chk("R7 stall released", int'(alloc_stall), 0);
            chk("R5 drain order", pid(4), k);
        end
        step(); #1;
        chk("R7 dropped alloc absent", int'(disp_valid), 0);

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule